// File: doc/BRIEF.md
# Pipelined Bus Cycle Issue Controller

This block sits between a processor's internal bus-request logic and an external bus whose cycles are closed by an active-low ready strobe. It accepts one request at a time. Each request carries an address, a memory-or-I/O flag, a data-or-code flag, a read-or-write flag, two byte enables, a lock flag and an interrupt-acknowledge flag. The block drives the request onto the bus as a cycle definition and marks the first clock with an active-low address strobe.

The system can ask for address pipelining with an active-low next-address input. If that input is low while a cycle is still waiting for ready, and a request is waiting, the next cycle's address and definition are driven before the current cycle ends. Only one such early cycle may be outstanding at a time.

The block also drives an active-low lock output that keeps other masters off the bus. It answers a hold request from another master with a hold acknowledge. The acknowledge is given only at a clean cycle boundary and never while lock is active. While hold acknowledge is high, the address and definition outputs are released.

Top module: `bus_issue_ctl`

## Requirements
- R1: After reset the address strobe and lock outputs are high (inactive), hold acknowledge is low, the output-drive enable is high and no request is accepted until one is presented.
- R2: A request presented while the bus is idle is accepted in the same clock (req_ready high). On the next clock the bus carries its address and definition, and the address strobe is low for exactly that one clock.
- R3: The memory/IO output is 1 for memory cycles and 0 for I/O cycles. The write/read output is 1 for writes. The high and low byte-enable outputs are the inverse of req_be[1] and req_be[0].
- R4: A waiting request is accepted and issued while the current cycle has not yet seen ready, provided next-address is low and no early cycle is outstanding.
- R5: While one early-issued cycle is outstanding, no further request is accepted until the current cycle receives ready. Ready promotes the early cycle to current, and only then can another early issue occur.
- R6: The lock output goes low with the issue of a cycle whose lock flag is set. It stays low until that cycle completes. It also stays low across the gap to a waiting request that is itself locked.
- R7: An interrupt-acknowledge request is always locked and is driven with memory/IO, data/code and write/read all low.
- R8: Hold acknowledge rises one clock after hold is sampled high at a cycle boundary where no cycle is in progress, or the current cycle ends with no early cycle outstanding. The lock output must also be inactive at that point. Hold takes priority over a waiting request at that boundary.
- R9: Hold acknowledge is never high while the lock output is low, and an outstanding early-issued cycle delays it until that cycle has also completed.
- R10: While hold acknowledge is high, the output-drive enable is low and no request is accepted. Hold acknowledge falls one clock after hold is sampled low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Internal request waiting |
| req_addr | input | AW | Request address |
| req_mem | input | 1 | 1 = memory cycle, 0 = I/O cycle |
| req_code | input | 1 | 1 = data, 0 = code/control |
| req_write | input | 1 | 1 = write, 0 = read |
| req_be | input | 2 | Byte enables, bit 1 high byte, bit 0 low byte (active high) |
| req_lock | input | 1 | Request belongs to a locked sequence |
| req_inta | input | 1 | Request is an interrupt acknowledge |
| req_ready | output | 1 | Request accepted this clock |
| bus_addr | output | AW | Bus address |
| bus_mio | output | 1 | Memory/IO definition |
| bus_dc | output | 1 | Data/code definition |
| bus_wr | output | 1 | Write/read definition |
| bus_bhe_n | output | 1 | High byte enable, active low |
| bus_ble_n | output | 1 | Low byte enable, active low |
| bus_ads_n | output | 1 | Address strobe, active low |
| bus_lock_n | output | 1 | Bus lock, active low |
| bus_drive | output | 1 | Output-drive enable for address and definition pads |
| bus_ready_n | input | 1 | Cycle-ending ready, active low |
| bus_na_n | input | 1 | Next-address request, active low |
| hold | input | 1 | Bus hold request from another master |
| hlda | output | 1 | Hold acknowledge |

## Verification
The hardest case to reach is the one where hold arrives while an early-issued cycle is outstanding behind the current one. Here the block must withhold acknowledge across the first ready and grant it only after the second. The bench gets there in three steps. It starts a cycle, then presents a second request with next-address low and ready high so that it issues early. It then raises hold before it supplies the two ready pulses one at a time, and checks hold acknowledge after each. A similar sequence keeps lock active across two locked requests while hold is pending.

// File: rtl/bus_issue_ctl.sv
module bus_issue_ctl #(
  parameter int AW = 23
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  logic          req_mem,
  input  logic          req_code,
  input  logic          req_write,
  input  logic [1:0]    req_be,
  input  logic          req_lock,
  input  logic          req_inta,
  output logic          req_ready,
  output logic [AW-1:0] bus_addr,
  output logic          bus_mio,
  output logic          bus_dc,
  output logic          bus_wr,
  output logic          bus_bhe_n,
  output logic          bus_ble_n,
  output logic          bus_ads_n,
  output logic          bus_lock_n,
  output logic          bus_drive,
  input  logic          bus_ready_n,
  input  logic          bus_na_n,
  input  logic          hold,
  output logic          hlda
);

  logic          cur_v, cur_lk, pend_v, pend_lk;
  logic          nx_cur_v, nx_cur_lk, nx_pend_v, nx_pend_lk;
  logic          lock_q, hlda_q, ads_q;
  logic [AW-1:0] addr_q;
  logic          mio_q, dc_q, wr_q;
  logic [1:0]    be_q;

  wire eff_lk     = req_lock | req_inta;
  wire end_cyc    = cur_v & ~bus_ready_n;
  wire boundary   = ~cur_v | (end_cyc & ~pend_v);
  wire grant_ok   = ~hlda_q & hold & ~lock_q & boundary;
  wire start_new  = req_valid & ~hlda_q & ~grant_ok & boundary;
  wire start_pipe = req_valid & ~hlda_q & cur_v & bus_ready_n & ~bus_na_n & ~pend_v;
  wire issue      = start_new | start_pipe;

  always_comb begin
    nx_cur_v   = cur_v;
    nx_cur_lk  = cur_lk;
    nx_pend_v  = pend_v;
    nx_pend_lk = pend_lk;
    if (end_cyc) begin
      nx_cur_v  = pend_v;
      nx_cur_lk = pend_lk;
      nx_pend_v = 1'b0;
    end
    if (start_new) begin
      nx_cur_v  = 1'b1;
      nx_cur_lk = eff_lk;
    end
    if (start_pipe) begin
      nx_pend_v  = 1'b1;
      nx_pend_lk = eff_lk;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_v   <= 1'b0;
      cur_lk  <= 1'b0;
      pend_v  <= 1'b0;
      pend_lk <= 1'b0;
      lock_q  <= 1'b0;
      hlda_q  <= 1'b0;
      ads_q   <= 1'b0;
      addr_q  <= '0;
      mio_q   <= 1'b0;
      dc_q    <= 1'b0;
      wr_q    <= 1'b0;
      be_q    <= 2'b00;
    end else begin
      cur_v   <= nx_cur_v;
      cur_lk  <= nx_cur_lk;
      pend_v  <= nx_pend_v;
      pend_lk <= nx_pend_lk;
      lock_q  <= (nx_cur_v & nx_cur_lk) | (nx_pend_v & nx_pend_lk) |
                 (lock_q & req_valid & eff_lk & ~hlda_q);
      hlda_q  <= hlda_q ? hold : grant_ok;
      ads_q   <= issue;
      if (issue) begin
        addr_q <= req_addr;
        mio_q  <= req_mem & ~req_inta;
        dc_q   <= req_code & ~req_inta;
        wr_q   <= req_write & ~req_inta;
        be_q   <= req_be;
      end
    end
  end

  assign req_ready  = issue;
  assign bus_addr   = addr_q;
  assign bus_mio    = mio_q;
  assign bus_dc     = dc_q;
  assign bus_wr     = wr_q;
  assign bus_bhe_n  = ~be_q[1];
  assign bus_ble_n  = ~be_q[0];
  assign bus_ads_n  = ~ads_q;
  assign bus_lock_n = ~lock_q;
  assign bus_drive  = ~hlda_q;
  assign hlda       = hlda_q;

  // R2
  accept_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |=> !bus_ads_n);

  // R7
  inta_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && req_inta) |=> (!bus_lock_n && !bus_mio && !bus_dc && !bus_wr));

  // R8
  hlda_after_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hlda) |-> $past(hold));

  // R9
  hlda_lock_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(hlda && !bus_lock_n));

  // R10
  no_issue_in_hlda_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hlda |-> !req_ready);

  // R10
  hlda_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hlda && !hold) |=> !hlda);

endmodule

// File: tb/bus_issue_ctl_test.sv
module bus_issue_ctl_test;
  localparam int AW = 23;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic          req_mem = 1'b0, req_code = 1'b0, req_write = 1'b0;
  logic [1:0]    req_be = 2'b00;
  logic          req_lock = 1'b0, req_inta = 1'b0;
  logic          req_ready;
  logic [AW-1:0] bus_addr;
  logic          bus_mio, bus_dc, bus_wr, bus_bhe_n, bus_ble_n;
  logic          bus_ads_n, bus_lock_n, bus_drive, hlda;
  logic          bus_ready_n = 1'b1, bus_na_n = 1'b1, hold = 1'b0;

  int total = 0;
  int bad = 0;

  bus_issue_ctl #(.AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_mem(req_mem), .req_code(req_code), .req_write(req_write),
    .req_be(req_be), .req_lock(req_lock), .req_inta(req_inta),
    .req_ready(req_ready), .bus_addr(bus_addr), .bus_mio(bus_mio),
    .bus_dc(bus_dc), .bus_wr(bus_wr), .bus_bhe_n(bus_bhe_n),
    .bus_ble_n(bus_ble_n), .bus_ads_n(bus_ads_n), .bus_lock_n(bus_lock_n),
    .bus_drive(bus_drive), .bus_ready_n(bus_ready_n), .bus_na_n(bus_na_n),
    .hold(hold), .hlda(hlda)
  );

  always #4 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic put(input logic [AW-1:0] a, input logic m, input logic d,
                     input logic w, input logic [1:0] be, input logic lk, input logic ia);
    req_valid = 1'b1; req_addr = a; req_mem = m; req_code = d;
    req_write = w; req_be = be; req_lock = lk; req_inta = ia;
  endtask

  task automatic drop();
    req_valid = 1'b0; req_lock = 1'b0; req_inta = 1'b0;
  endtask

  task automatic finish_cycle();
    bus_ready_n = 1'b0;
    step();
    bus_ready_n = 1'b1;
  endtask

  task automatic t_reset();
    chk("R1 ads_n", bus_ads_n, 1);
    chk("R1 lock_n", bus_lock_n, 1);
    chk("R1 hlda", hlda, 0);
    chk("R1 drive", bus_drive, 1);
    chk("R1 req_ready", req_ready, 0);
  endtask

  task automatic t_basic();
    put(23'h01234, 1, 1, 0, 2'b11, 0, 0);
    #1 chk("R2 accept idle", req_ready, 1);
    step();
    drop();
    chk("R2 addr", bus_addr, 23'h01234);
    chk("R2 ads low", bus_ads_n, 0);
    chk("R3 mio mem", bus_mio, 1);
    chk("R3 wr read", bus_wr, 0);
    chk("R3 bhe_n", bus_bhe_n, 0);
    chk("R3 ble_n", bus_ble_n, 0);
    step();
    chk("R2 ads one clock", bus_ads_n, 1);
    finish_cycle();
  endtask

  task automatic t_io();
    put(23'h00060, 0, 1, 1, 2'b01, 0, 0);
    step();
    drop();
    chk("R3 mio io", bus_mio, 0);
    chk("R3 wr write", bus_wr, 1);
    chk("R3 bhe_n off", bus_bhe_n, 1);
    chk("R3 ble_n on", bus_ble_n, 0);
    finish_cycle();
  endtask

  task automatic t_pipe();
    put(23'h00100, 1, 1, 0, 2'b11, 0, 0);
    step();
    put(23'h00200, 1, 1, 0, 2'b11, 0, 0);
    bus_na_n = 1'b0;
    #1 chk("R4 early accept", req_ready, 1);
    step();
    chk("R4 early addr", bus_addr, 23'h00200);
    chk("R4 early strobe", bus_ads_n, 0);
    put(23'h00300, 1, 1, 0, 2'b11, 0, 0);
    #1 chk("R5 second early blocked", req_ready, 0);
    bus_ready_n = 1'b0;
    #1 chk("R5 blocked at ready", req_ready, 0);
    step();
    bus_ready_n = 1'b1;
    chk("R5 addr held", bus_addr, 23'h00200);
    #1 chk("R5 early after ready", req_ready, 1);
    step();
    drop();
    bus_na_n = 1'b1;
    chk("R5 third addr", bus_addr, 23'h00300);
    finish_cycle();
    finish_cycle();
    chk("R5 idle accept", 32'(req_ready), 0);
  endtask

  task automatic t_lock();
    put(23'h00400, 1, 1, 0, 2'b11, 1, 0);
    step();
    chk("R6 lock low", bus_lock_n, 0);
    hold = 1'b1;
    put(23'h00400, 1, 1, 1, 2'b11, 1, 0);
    bus_ready_n = 1'b0;
    #1 chk("R6 locked follow-on accepted", req_ready, 1);
    step();
    bus_ready_n = 1'b1;
    drop();
    chk("R9 no hlda under lock", hlda, 0);
    chk("R6 lock kept", bus_lock_n, 0);
    finish_cycle();
    chk("R6 lock released", bus_lock_n, 1);
    chk("R9 hlda waits", hlda, 0);
    step();
    chk("R8 hlda after unlock", hlda, 1);
    hold = 1'b0;
    step();
    chk("R10 hlda falls", hlda, 0);
  endtask

  task automatic t_hold();
    hold = 1'b1;
    put(23'h00500, 1, 1, 0, 2'b11, 0, 0);
    #1 chk("R8 hold beats request", req_ready, 0);
    step();
    chk("R8 hlda", hlda, 1);
    chk("R10 drive off", bus_drive, 0);
    #1 chk("R10 no accept", req_ready, 0);
    step();
    chk("R10 no strobe", bus_ads_n, 1);
    hold = 1'b0;
    #1 chk("R10 still blocked", req_ready, 0);
    step();
    chk("R10 hlda released", hlda, 0);
    chk("R10 drive on", bus_drive, 1);
    #1 chk("R10 accept after release", req_ready, 1);
    step();
    drop();
    chk("R10 addr", bus_addr, 23'h00500);
    finish_cycle();
  endtask

  task automatic t_hold_pipe();
    put(23'h00600, 1, 1, 0, 2'b11, 0, 0);
    step();
    put(23'h00700, 1, 1, 0, 2'b11, 0, 0);
    bus_na_n = 1'b0;
    step();
    drop();
    bus_na_n = 1'b1;
    hold = 1'b1;
    finish_cycle();
    chk("R9 early cycle delays hlda", hlda, 0);
    step();
    chk("R9 still waiting", hlda, 0);
    finish_cycle();
    chk("R8 hlda after last", hlda, 1);
    hold = 1'b0;
    step();
    chk("R10 released", hlda, 0);
  endtask

  task automatic t_inta();
    put(23'h00000, 1, 1, 1, 2'b11, 0, 1);
    step();
    drop();
    chk("R7 lock", bus_lock_n, 0);
    chk("R7 mio", bus_mio, 0);
    chk("R7 dc", bus_dc, 0);
    chk("R7 wr", bus_wr, 0);
    finish_cycle();
    chk("R7 unlock", bus_lock_n, 1);
  endtask

  initial begin
    #1000000;
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    step();
    step();
    t_reset();
    rst_n = 1'b1;
    step();
    t_reset();
    t_basic();
    t_io();
    t_pipe();
    t_lock();
    t_hold();
    t_hold_pipe();
    t_inta();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule